// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Manager

This block holds a protection state for every erase block of a flash array. Program and erase logic use it to decide whether a block may be changed. Each block is in exactly one of three states:

- **open**: writes are allowed.
- **locked**: writes are refused, but the block can be reopened.
- **tight**: the block is frozen until the next reset.

The host sets a first-block register and a last-block register, then issues a range command. The block walks from the first address to the last, one block per clock, and applies the rule for that command to each block. A combinational query port reports the state of any single block. A status output holds the state most recently written by a walk.

A walk holds `busy` high from the cycle after the command is accepted until it ends. It ends with a one-cycle `done` pulse, and `doneErr` flags a rejected command. Commands offered while `busy` is high are dropped.

Top module: `blk_lock_mgr`

## Requirements
- R1: State encodings are one-hot: tight = 3'b001, locked = 3'b010, open = 3'b100. After reset, every block is locked, `wpStatus` is 3'b010, both range registers read 0 and `busy` is low.
- R2: A write with `regSel`=0 stores `regWrData` masked to NUM_BLOCKS-1 into the first-block register and the same value into the last-block register. A write with `regSel`=1 changes only the last-block register.
- R3: Opcode 8'h23 opens every block from the first address to the last, inclusive. Tight blocks in the range are skipped.
- R4: Opcode 8'h27 opens every block of the array, skipping tight blocks, regardless of the range registers.
- R5: Opcode 8'h2A locks every block of the range, skipping tight blocks.
- R6: Opcode 8'h2C makes every locked or tight block of the range tight, and skips open blocks. A tight block stays tight until reset.
- R7: Each block a walk writes copies its new state into `wpStatus`. A skipped block leaves `wpStatus` unchanged.
- R8: A command is accepted on a clock edge where `cmdValid` is high and `busy` is low. A walk of k blocks updates one block per edge on the k edges after acceptance. `done` is high for the single cycle after the k-th edge, and `busy` falls in that same cycle.
- R9: `cmdValid` is ignored while `busy` is high: no second walk starts and no extra `done` appears.
- R10: An unknown opcode, or a range command whose first address is greater than its last, produces `done` with `doneErr` one cycle after acceptance. No block state and no `wpStatus` change.
- R11: `queryState` gives the current state of block `queryIdx` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Range register write strobe |
| regSel | input | 1 | Register select: 0 = first block, 1 = last block |
| regWrData | input | DATA_W | Register write data |
| cmdValid | input | 1 | Command offer |
| cmdOp | input | 8 | Command opcode |
| queryIdx | input | IDX_W | Block to query |
| queryState | output | 3 | One-hot state of the queried block |
| wpStatus | output | 3 | Last state written by a walk |
| startBlk | output | IDX_W | First-block register |
| endBlk | output | IDX_W | Last-block register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| doneErr | output | 1 | Error flag, valid with `done` |

## Verification
A range of k blocks must produce `done` exactly k edges after the accepting edge. A rejected command must produce `done` after one edge. The bench raises `cmdValid` at a falling edge and counts falling edges until `done` is seen, then compares that count with the expected k. Register values and query results are sampled one nanosecond after a falling edge, so the state of each block is read only after the last edge of the walk that could change it.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;

  typedef enum logic [2:0] {
    LK_TIGHT  = 3'b001,
    LK_LOCKED = 3'b010,
    LK_OPEN   = 3'b100
  } lockState_t;

  localparam logic [7:0] OPC_OPEN_RANGE  = 8'h23;
  localparam logic [7:0] OPC_OPEN_ALL    = 8'h27;
  localparam logic [7:0] OPC_LOCK_RANGE  = 8'h2A;
  localparam logic [7:0] OPC_TIGHT_RANGE = 8'h2C;

  typedef enum logic [1:0] {
    WK_OPEN  = 2'd0,
    WK_LOCK  = 2'd1,
    WK_TIGHT = 2'd2
  } walkKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;     // accept: load cursor and limit
    logic      loadAll;  // whole-array walk
    logic      apply;    // process block at cursor this edge
    walkKind_t kind;
  } walkCtl_t;

endpackage

// File: rtl/lockmgr_ctrl.sv
module lockmgr_ctrl
  import lockmgr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [7:0] cmdOp,
  input  logic       atLimit,
  input  logic       rangeBad,
  output walkCtl_t   ctl,
  output logic       busy,
  output logic       done,
  output logic       doneErr
);

  logic      busyQ, errQ, doneQ, doneErrQ;
  walkKind_t kindQ;
  walkKind_t kindD;
  logic      knownD, allD;

  always_comb begin
    knownD = 1'b1;
    allD   = 1'b0;
    kindD  = WK_OPEN;
    case (cmdOp)
      OPC_OPEN_RANGE:  kindD = WK_OPEN;
      OPC_OPEN_ALL:    allD  = 1'b1;
      OPC_LOCK_RANGE:  kindD = WK_LOCK;
      OPC_TIGHT_RANGE: kindD = WK_TIGHT;
      default:         knownD = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ    <= 1'b0;
      errQ     <= 1'b0;
      doneQ    <= 1'b0;
      doneErrQ <= 1'b0;
      kindQ    <= WK_OPEN;
    end else begin
      doneQ    <= 1'b0;
      doneErrQ <= 1'b0;
      if (!busyQ) begin
        if (cmdValid) begin
          busyQ <= 1'b1;
          kindQ <= kindD;
          errQ  <= !knownD || (!allD && rangeBad);
        end
      end else if (errQ) begin
        busyQ    <= 1'b0;
        doneQ    <= 1'b1;
        doneErrQ <= 1'b1;
      end else if (atLimit) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.load    = !busyQ && cmdValid;
    ctl.loadAll = allD;
    ctl.apply   = busyQ && !errQ;
    ctl.kind    = busyQ ? kindQ : kindD;
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign doneErr = doneErrQ;

endmodule

// File: rtl/lockmgr_dp.sv
module lockmgr_dp
  import lockmgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  walkCtl_t          ctl,
  input  logic [IDX_W-1:0]  queryIdx,
  output logic [2:0]        queryState,
  output logic [2:0]        wpStatus,
  output logic [IDX_W-1:0]  startBlk,
  output logic [IDX_W-1:0]  endBlk,
  output logic              atLimit,
  output logic              rangeBad
);

  lockState_t [NUM_BLOCKS-1:0] lockQ;
  lockState_t                  wpQ;
  logic [IDX_W-1:0]            startQ, endQ, cursorQ, limitQ;

  lockState_t curState, newState;
  logic       wrEn;

  // power-of-two count: truncation is the mask by NUM_BLOCKS-1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startQ <= '0;
      endQ   <= '0;
    end else if (regWrEn) begin
      if (!regSel) begin
        startQ <= regWrData[IDX_W-1:0];
        endQ   <= regWrData[IDX_W-1:0];
      end else begin
        endQ   <= regWrData[IDX_W-1:0];
      end
    end
  end

  assign atLimit  = (cursorQ == limitQ);
  assign rangeBad = (startQ > endQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cursorQ <= '0;
      limitQ  <= '0;
    end else if (ctl.load) begin
      cursorQ <= ctl.loadAll ? '0 : startQ;
      limitQ  <= ctl.loadAll ? '1 : endQ;
    end else if (ctl.apply && !atLimit) begin
      cursorQ <= cursorQ + 1'b1;
    end
  end

  always_comb begin
    curState = lockQ[cursorQ];
    wrEn     = 1'b0;
    newState = LK_LOCKED;
    case (ctl.kind)
      WK_OPEN: begin
        wrEn     = (curState != LK_TIGHT);
        newState = LK_OPEN;
      end
      WK_LOCK: begin
        wrEn     = (curState != LK_TIGHT);
        newState = LK_LOCKED;
      end
      WK_TIGHT: begin
        wrEn     = (curState != LK_OPEN);
        newState = LK_TIGHT;
      end
      default: wrEn = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLOCKS; i++) lockQ[i] <= LK_LOCKED;
      wpQ <= LK_LOCKED;
    end else if (ctl.apply && wrEn) begin
      lockQ[cursorQ] <= newState;
      wpQ            <= newState;
    end
  end

  assign queryState = lockQ[queryIdx];
  assign wpStatus   = wpQ;
  assign startBlk   = startQ;
  assign endBlk     = endQ;

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import lockmgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [IDX_W-1:0]  queryIdx,
  output logic [2:0]        queryState,
  output logic [2:0]        wpStatus,
  output logic [IDX_W-1:0]  startBlk,
  output logic [IDX_W-1:0]  endBlk,
  output logic              busy,
  output logic              done,
  output logic              doneErr
);

  walkCtl_t ctl;
  logic     atLimit, rangeBad;

  lockmgr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .atLimit(atLimit), .rangeBad(rangeBad), .ctl(ctl),
    .busy(busy), .done(done), .doneErr(doneErr)
  );

  lockmgr_dp #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ctl(ctl), .queryIdx(queryIdx),
    .queryState(queryState), .wpStatus(wpStatus), .startBlk(startBlk),
    .endBlk(endBlk), .atLimit(atLimit), .rangeBad(rangeBad)
  );

endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             regWrEn,
  input logic             regSel,
  input logic             cmdValid,
  input logic [IDX_W-1:0] queryIdx,
  input logic [2:0]       queryState,
  input logic [2:0]       wpStatus,
  input logic [IDX_W-1:0] startBlk,
  input logic [IDX_W-1:0] endBlk,
  input logic             busy,
  input logic             done,
  input logic             doneErr
);

  p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(queryState) == 1);

  p_wp_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wpStatus) == 1);

  p_first_copies_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regSel) |=> (startBlk == endBlk));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmdValid) |=> busy);

  p_done_ends_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doneErr |-> done);

  p_tight_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((queryIdx == $past(queryIdx)) && ($past(queryState) == 3'b001))
      |-> (queryState == 3'b001));

endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regSel(regSel),
  .cmdValid(cmdValid), .queryIdx(queryIdx), .queryState(queryState),
  .wpStatus(wpStatus), .startBlk(startBlk), .endBlk(endBlk),
  .busy(busy), .done(done), .doneErr(doneErr)
);

// File: tb/sim_blk_lock_mgr.sv
module sim_blk_lock_mgr;

  localparam int NB = 16;
  localparam int IW = 4;
  localparam logic [2:0] ST_T = 3'b001, ST_L = 3'b010, ST_O = 3'b100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regSel = 1'b0;
  logic [15:0]   regWrData = '0;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdOp = '0;
  logic [IW-1:0] queryIdx = '0;
  logic [2:0]    queryState, wpStatus;
  logic [IW-1:0] startBlk, endBlk;
  logic          busy, done, doneErr;

  int checks = 0;
  int failures = 0;

  blk_lock_mgr #(.NUM_BLOCKS(NB), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .queryIdx(queryIdx), .queryState(queryState), .wpStatus(wpStatus),
    .startBlk(startBlk), .endBlk(endBlk), .busy(busy), .done(done),
    .doneErr(doneErr)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expBlk(input string req, input int idx, input logic [2:0] exp);
    queryIdx = idx[IW-1:0];
    #1;
    check(req, {29'd0, queryState}, {29'd0, exp});
  endtask

  task automatic setReg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // returns falling edges counted from the accepting edge until done is seen
  task automatic runCmd(input logic [7:0] op, output int cyc, output logic err);
    @(negedge clk);
    cmdOp = op; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R8 busy after accept", {31'd0, busy}, 32'd1);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 100);
    err = doneErr;
    #1;
    check("R8 busy low with done", {31'd0, busy}, 32'd0);
  endtask

  task automatic tReset();
    check("R1 busy at reset", {31'd0, busy}, 32'd0);
    check("R1 wp at reset", {29'd0, wpStatus}, 32'd2);
    check("R1 start at reset", {28'd0, startBlk}, 32'd0);
    check("R1 end at reset", {28'd0, endBlk}, 32'd0);
    for (int i = 0; i < NB; i++) expBlk("R1 block locked at reset", i, ST_L);
  endtask

  task automatic tRegs();
    setReg(1'b0, 16'h0025);
    check("R2 start masked", {28'd0, startBlk}, 32'd5);
    check("R2 end copied", {28'd0, endBlk}, 32'd5);
    setReg(1'b1, 16'h0009);
    check("R2 end only", {28'd0, endBlk}, 32'd9);
    check("R2 start kept", {28'd0, startBlk}, 32'd5);
  endtask

  task automatic tOpenRange();
    int c; logic e;
    runCmd(8'h23, c, e);
    check("R8 open range cycles", c, 32'd5);
    check("R3 no error", {31'd0, e}, 32'd0);
    for (int i = 5; i <= 9; i++) expBlk("R3 block opened", i, ST_O);
    expBlk("R3 below range kept", 4, ST_L);
    expBlk("R3 above range kept", 10, ST_L);
    check("R7 wp open", {29'd0, wpStatus}, 32'd4);
  endtask

  task automatic tTightRange();
    int c; logic e;
    setReg(1'b0, 16'd3);
    setReg(1'b1, 16'd6);
    runCmd(8'h2C, c, e);
    check("R8 tight cycles", c, 32'd4);
    expBlk("R6 locked to tight", 3, ST_T);
    expBlk("R6 locked to tight", 4, ST_T);
    expBlk("R6 open skipped", 5, ST_O);
    expBlk("R6 open skipped", 6, ST_O);
    check("R7 wp keeps last written", {29'd0, wpStatus}, {29'd0, ST_T});
  endtask

  task automatic tOpenAll();
    int c; logic e;
    runCmd(8'h27, c, e);
    check("R4 open all cycles", c, NB);
    expBlk("R4 tight kept", 3, ST_T);
    expBlk("R4 tight kept", 4, ST_T);
    expBlk("R4 first opened", 0, ST_O);
    expBlk("R4 last opened", 15, ST_O);
    check("R7 wp after open all", {29'd0, wpStatus}, {29'd0, ST_O});
  endtask

  task automatic tLockRange();
    int c; logic e;
    setReg(1'b0, 16'd0);
    setReg(1'b1, 16'd15);
    runCmd(8'h2A, c, e);
    check("R5 lock cycles", c, NB);
    expBlk("R5 tight kept", 4, ST_T);
    expBlk("R5 block locked", 0, ST_L);
    expBlk("R5 block locked", 9, ST_L);
    check("R7 wp locked", {29'd0, wpStatus}, {29'd0, ST_L});
  endtask

  task automatic tBusyIgnore();
    int dones = 0;
    setReg(1'b0, 16'd10);
    setReg(1'b1, 16'd12);
    @(negedge clk);
    cmdOp = 8'h23; cmdValid = 1'b1;
    @(negedge clk);
    cmdOp = 8'h27;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R9 single done", dones, 32'd1);
    expBlk("R9 second command dropped", 0, ST_L);
    expBlk("R3 range block opened", 11, ST_O);
    expBlk("R3 past range kept", 13, ST_L);
  endtask

  task automatic tErrors();
    int c; logic e;
    setReg(1'b0, 16'd8);
    setReg(1'b1, 16'd2);
    runCmd(8'h23, c, e);
    check("R10 reversed range cycles", c, 32'd1);
    check("R10 reversed range error", {31'd0, e}, 32'd1);
    expBlk("R10 no change", 8, ST_L);
    expBlk("R10 no change", 2, ST_L);
    check("R10 wp unchanged", {29'd0, wpStatus}, {29'd0, ST_O});
    runCmd(8'h55, c, e);
    check("R10 bad opcode cycles", c, 32'd1);
    check("R10 bad opcode error", {31'd0, e}, 32'd1);
    check("R10 wp unchanged op", {29'd0, wpStatus}, {29'd0, ST_O});
  endtask

  task automatic tSingle();
    int c; logic e;
    setReg(1'b0, 16'd7);
    runCmd(8'h2C, c, e);
    check("R8 single block cycles", c, 32'd1);
    check("R6 no error", {31'd0, e}, 32'd0);
    expBlk("R6 single tight", 7, ST_T);
    expBlk("R6 neighbour kept", 6, ST_L);
    expBlk("R11 neighbour kept", 8, ST_L);
    check("R7 wp tight", {29'd0, wpStatus}, {29'd0, ST_T});
  endtask

  task automatic tReReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expBlk("R1 tight cleared by reset", 7, ST_L);
    expBlk("R1 tight cleared by reset", 3, ST_L);
    check("R1 wp after reset", {29'd0, wpStatus}, 32'd2);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tOpenRange();
    tTightRange();
    tOpenAll();
    tLockRange();
    tBusyIgnore();
    tErrors();
    tSingle();
    tReReset();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule